// File: doc/BRIEF.md
# Sample-and-Hold Bus Programming Sequencer

This block sits on the host side of a multiplexed analog hold bus and turns one command at a time into a timed pin sequence. A command is a kind code, a 4-bit address field and a 12-bit value. Mode writes and the group clear pulse the sample strobe briefly with no auto-zero. An analog write first loads a DAC with the value, waits for the DAC to settle, presents the channel address, and then holds the sample strobe low for a long pulse. A shorter auto-zero pulse sits inside the first half of that pulse. The controller enforces three rules. The clear must come first after reset. Bus activity may only start while the blanking input is high. Two analog updates may not come closer than the 30 kHz limit allows.

Every pulse width is a cycle count derived from the clock frequency parameter `CLK_MHZ`. The defaults at 125 MHz are:
- mode/clear strobe DIG = ceil(100·CLK_MHZ/1000)+1 = 14 cycles;
- address setup SU = ceil(25·CLK_MHZ/1000) = 4 cycles;
- auto-zero lead LEAD = 4 cycles;
- auto-zero width AZ = 10·CLK_MHZ = 1250 cycles;
- analog sample width SMP = max(20·CLK_MHZ, 2·(LEAD+AZ)) = 2508 cycles;
- DAC settle SETTLE = 64 cycles;
- analog spacing GAP = ceil(1000·CLK_MHZ/30) = 4167 cycles.

The state machine has the states IDLE, WAIT, LOAD, SETTLE, SETUP, LEAD, ZERO, TAIL and STROBE. Its transitions are:
- IDLE→WAIT on acceptance.
- WAIT→LOAD when the command is analog, blanking is high and the spacing rule allows it.
- WAIT→SETUP when the command is a mode or clear write and blanking is high.
- LOAD→SETTLE after one cycle.
- SETTLE→SETUP after SETTLE cycles.
- SETUP→LEAD for an analog write, or SETUP→STROBE for a mode or clear write, after SU cycles.
- LEAD→ZERO after LEAD cycles.
- ZERO→TAIL after AZ cycles.
- TAIL→IDLE after SMP−LEAD−AZ cycles.
- STROBE→IDLE after DIG cycles.

Top module: `hold_bus_seq`

## Requirements
- R1: While and after reset, with no command: bus_addr is 4'b1111, sample_n and zero_n are 1, dac_load, busy and cmd_err are 0.
- R2: Until a clear write has finished, any command other than a clear is rejected with a one-cycle cmd_err and does not run. Kind encoding: 2'b00 mode write, 2'b01 clear, 2'b10 analog write, 2'b11 illegal.
- R3: A clear drives bus_addr 4'b1110 for SU cycles, then holds sample_n low for DIG cycles with the address unchanged. zero_n stays high.
- R4: A mode write drives bus_addr = cmd_addr for SU cycles, then holds sample_n low for DIG cycles. zero_n stays high.
- R5: An analog write sets dac_data to cmd_data at acceptance. It pulses dac_load for exactly one cycle in LOAD, then waits SETTLE cycles with bus_addr still 4'b1111.
- R6: An analog write then drives bus_addr = {1'b0, cmd_addr[2:0]} for SU cycles, then holds sample_n low for SMP cycles with the address stable.
- R7: zero_n goes low LEAD cycles after sample_n falls and stays low for AZ cycles. The pulse ends within the first half of the sample pulse.
- R8: A new analog write leaves WAIT only once more than GAP cycles have passed since the previous analog sample_n fall. Consecutive analog falls are therefore more than GAP cycles apart.
- R9: An accepted command waits in WAIT, with the bus idle, while blank is low. Once started, it runs to completion even if blank falls.
- R10: busy is high from the cycle after acceptance until bus_addr returns to 4'b1111. A command presented while busy is ignored and produces a one-cycle cmd_err in the next cycle.
- R11: Kind code 2'b11 is rejected with cmd_err and runs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blank | input | 1 | High during the scan blanking window |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_kind | input | 2 | Command kind code |
| cmd_addr | input | 4 | Mode address, or analog channel in bits 2:0 |
| cmd_data | input | 12 | Analog value for the DAC |
| bus_addr | output | 4 | Hold-bus address |
| sample_n | output | 1 | Active-low sample strobe |
| zero_n | output | 1 | Active-low auto-zero strobe |
| dac_data | output | 12 | DAC data word |
| dac_load | output | 1 | DAC load strobe |
| busy | output | 1 | Command in progress |
| cmd_err | output | 1 | One-cycle rejection pulse |

## Verification
The bench sends commands before the clear has finished. A sequencer lacking clear-first gating would run them and move the address off idle. It holds blanking low across an accepted clear: a design that ignores the window starts the strobe at once. It also drops blanking in the middle of an analog pulse, where a design that aborts would cut the sample short. Back-to-back analog writes check the spacing rule. A too-eager design lets the second fall arrive early. Exact per-cycle comparison of the auto-zero edges catches a pulse that is shifted, too long, or spills past the first half.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    typedef enum logic [1:0] {
        K_MODE   = 2'b00,
        K_CLEAR  = 2'b01,
        K_ANALOG = 2'b10,
        K_BAD    = 2'b11
    } cmd_kind_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WAIT,
        S_LOAD,
        S_SETTLE,
        S_SETUP,
        S_LEAD,
        S_ZERO,
        S_TAIL,
        S_STROBE
    } seq_state_e;

    localparam logic [3:0] ADDR_PARK  = 4'b1111;
    localparam logic [3:0] ADDR_CLEAR = 4'b1110;

endpackage

// File: rtl/hbs_phase_timer.sv
module hbs_phase_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic          done
);

    logic [CW-1:0] remain;

    // Loaded with len-1 on entry to a phase, so a phase lasts len cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= len - 1'b1;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign done = (remain == '0);

endmodule

// File: rtl/hbs_rate_guard.sv
module hbs_rate_guard #(
    parameter int GAP = 4167,
    localparam int GW = $clog2(GAP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark,
    output logic ok
);

    localparam logic [GW-1:0] GAP_V = GW'(GAP);

    logic [GW-1:0] since;

    // Saturating count of cycles since the last analog sample fall.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since <= GAP_V;
        end else if (mark) begin
            since <= '0;
        end else if (since < GAP_V) begin
            since <= since + 1'b1;
        end
    end

    assign ok = (since >= GAP_V);

endmodule

// File: rtl/hbs_cmd_gate.sv
module hbs_cmd_gate
    import hbs_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_kind,
    input  logic [3:0]    cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          busy,
    input  logic          cleared,
    output logic          accept,
    output logic          cmd_err,
    output cmd_kind_e     lat_kind,
    output logic [3:0]    lat_addr,
    output logic [DW-1:0] dac_data
);

    cmd_kind_e kind_in;
    logic      legal;

    assign kind_in = cmd_kind_e'(cmd_kind);
    assign legal   = (kind_in != K_BAD) && (cleared || kind_in == K_CLEAR);
    assign accept  = cmd_valid && !busy && legal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_err  <= 1'b0;
            lat_kind <= K_MODE;
            lat_addr <= ADDR_PARK;
            dac_data <= '0;
        end else begin
            cmd_err <= cmd_valid && !accept;
            if (accept) begin
                lat_kind <= kind_in;
                unique case (kind_in)
                    K_CLEAR:  lat_addr <= ADDR_CLEAR;
                    K_ANALOG: lat_addr <= {1'b0, cmd_addr[2:0]};
                    default:  lat_addr <= cmd_addr;
                endcase
                if (kind_in == K_ANALOG) begin
                    dac_data <= cmd_data;
                end
            end
        end
    end

endmodule

// File: rtl/hold_bus_seq.sv
module hold_bus_seq
    import hbs_pkg::*;
#(
    parameter int CLK_MHZ    = 125,
    parameter int DW         = 12,
    parameter int LEAD_CYC   = 4,
    parameter int SETTLE_CYC = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blank,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_kind,
    input  logic [3:0]    cmd_addr,
    input  logic [DW-1:0] cmd_data,
    output logic [3:0]    bus_addr,
    output logic          sample_n,
    output logic          zero_n,
    output logic [DW-1:0] dac_data,
    output logic          dac_load,
    output logic          busy,
    output logic          cmd_err
);

    localparam int DIG_CYC   = (100 * CLK_MHZ + 999) / 1000 + 1;
    localparam int SETUP_CYC = (25 * CLK_MHZ + 999) / 1000;
    localparam int AZ_CYC    = 10 * CLK_MHZ;
    localparam int SMP_MIN   = 20 * CLK_MHZ;
    localparam int SMP_CYC   = (SMP_MIN > 2 * (LEAD_CYC + AZ_CYC)) ? SMP_MIN : 2 * (LEAD_CYC + AZ_CYC);
    localparam int TAIL_CYC  = SMP_CYC - LEAD_CYC - AZ_CYC;
    localparam int GAP_CYC   = (1000 * CLK_MHZ + 29) / 30;
    localparam int MAX_LEN   = (SMP_CYC > SETTLE_CYC) ? SMP_CYC : SETTLE_CYC;
    localparam int CW        = $clog2(MAX_LEN + 1);
    localparam int KW        = $clog2(GAP_CYC + 1);

    seq_state_e    state, nxt;
    logic          accept, done, gap_ok, t_start, cleared, gap_mark;
    logic [CW-1:0] t_len;
    cmd_kind_e     lat_kind;
    logic [3:0]    lat_addr;

    hbs_cmd_gate #(.DW(DW)) u_gate (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .cleared(cleared),
        .accept(accept), .cmd_err(cmd_err), .lat_kind(lat_kind),
        .lat_addr(lat_addr), .dac_data(dac_data)
    );

    hbs_phase_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(t_start), .len(t_len), .done(done)
    );

    assign gap_mark = (state == S_SETUP) && done && (lat_kind == K_ANALOG);

    hbs_rate_guard #(.GAP(GAP_CYC)) u_guard (
        .clk(clk), .rst_n(rst_n), .mark(gap_mark), .ok(gap_ok)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Clear-first tracking (R2)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cleared <= 1'b0;
        end else if (state == S_STROBE && done && lat_kind == K_CLEAR) begin
            cleared <= 1'b1;
        end
    end

    // Next state and phase timer load
    always_comb begin
        nxt     = state;
        t_start = 1'b0;
        t_len   = CW'(1);
        unique case (state)
            S_IDLE: begin
                if (accept) nxt = S_WAIT;
            end
            S_WAIT: begin
                if (blank) begin
                    if (lat_kind == K_ANALOG) begin
                        if (gap_ok) begin
                            nxt     = S_LOAD;
                            t_start = 1'b1;
                            t_len   = CW'(1);
                        end
                    end else begin
                        nxt     = S_SETUP;
                        t_start = 1'b1;
                        t_len   = CW'(SETUP_CYC);
                    end
                end
            end
            S_LOAD: begin
                if (done) begin
                    nxt     = S_SETTLE;
                    t_start = 1'b1;
                    t_len   = CW'(SETTLE_CYC);
                end
            end
            S_SETTLE: begin
                if (done) begin
                    nxt     = S_SETUP;
                    t_start = 1'b1;
                    t_len   = CW'(SETUP_CYC);
                end
            end
            S_SETUP: begin
                if (done) begin
                    t_start = 1'b1;
                    if (lat_kind == K_ANALOG) begin
                        nxt   = S_LEAD;
                        t_len = CW'(LEAD_CYC);
                    end else begin
                        nxt   = S_STROBE;
                        t_len = CW'(DIG_CYC);
                    end
                end
            end
            S_LEAD: begin
                if (done) begin
                    nxt     = S_ZERO;
                    t_start = 1'b1;
                    t_len   = CW'(AZ_CYC);
                end
            end
            S_ZERO: begin
                if (done) begin
                    nxt     = S_TAIL;
                    t_start = 1'b1;
                    t_len   = CW'(TAIL_CYC);
                end
            end
            S_TAIL: begin
                if (done) nxt = S_IDLE;
            end
            S_STROBE: begin
                if (done) nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // Outputs decoded from the state register
    always_comb begin
        bus_addr = ADDR_PARK;
        sample_n = 1'b1;
        zero_n   = 1'b1;
        dac_load = 1'b0;
        busy     = 1'b1;
        unique case (state)
            S_IDLE:   busy = 1'b0;
            S_WAIT:   ;
            S_LOAD:   dac_load = 1'b1;
            S_SETTLE: ;
            S_SETUP:  bus_addr = lat_addr;
            S_LEAD: begin
                bus_addr = lat_addr;
                sample_n = 1'b0;
            end
            S_ZERO: begin
                bus_addr = lat_addr;
                sample_n = 1'b0;
                zero_n   = 1'b0;
            end
            S_TAIL: begin
                bus_addr = lat_addr;
                sample_n = 1'b0;
            end
            S_STROBE: begin
                bus_addr = lat_addr;
                sample_n = 1'b0;
            end
            default: busy = 1'b0;
        endcase
    end

    // ---------------- assertions ----------------
    logic          zero_q;
    logic [KW-1:0] chk_since;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zero_q    <= 1'b1;
            chk_since <= KW'(GAP_CYC);
        end else begin
            zero_q <= zero_n;
            if (zero_q && !zero_n) begin
                chk_since <= '0;
            end else if (chk_since < KW'(GAP_CYC)) begin
                chk_since <= chk_since + 1'b1;
            end
        end
    end

    p_zero_in_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_n |-> !sample_n);

    p_load_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |=> !dac_load);

    p_park_when_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_addr == ADDR_PARK && sample_n && zero_n && !dac_load));

    p_addr_before_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample_n) |-> ($stable(bus_addr) && bus_addr != ADDR_PARK));

    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_n |=> (sample_n || $stable(bus_addr)));

    p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_q && !zero_n) |-> (chk_since >= KW'(GAP_CYC)));

    p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(cmd_valid));

    p_clear_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_load || !zero_n) |-> cleared);

endmodule

// File: tb/hold_bus_seq_tb.sv
module hold_bus_seq_tb;

    localparam int CLK_MHZ = 125;
    localparam int DW      = 12;
    localparam int LEAD    = 4;
    localparam int SETTLE  = 64;
    localparam int DIG     = (100 * CLK_MHZ + 999) / 1000 + 1;
    localparam int SU      = (25 * CLK_MHZ + 999) / 1000;
    localparam int AZ      = 10 * CLK_MHZ;
    localparam int SMP     = (20 * CLK_MHZ > 2 * (LEAD + AZ)) ? 20 * CLK_MHZ : 2 * (LEAD + AZ);
    localparam int GAP     = (1000 * CLK_MHZ + 29) / 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          blank = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_kind = 2'b00;
    logic [3:0]    cmd_addr = 4'h0;
    logic [DW-1:0] cmd_data = '0;
    logic [3:0]    bus_addr;
    logic          sample_n, zero_n, dac_load, busy, cmd_err;
    logic [DW-1:0] dac_data;

    always #4 clk = ~clk;

    hold_bus_seq #(.CLK_MHZ(CLK_MHZ), .DW(DW), .LEAD_CYC(LEAD), .SETTLE_CYC(SETTLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .blank(blank), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .bus_addr(bus_addr), .sample_n(sample_n), .zero_n(zero_n),
        .dac_data(dac_data), .dac_load(dac_load), .busy(busy), .cmd_err(cmd_err)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit cmp_on = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // ---------------- behavioural reference ----------------
    longint        e = 0;
    bit            m_pend, m_run, m_clr, exp_err;
    int            m_kind;
    logic [3:0]    m_addr;
    logic [DW-1:0] exp_dac;
    longint        m_s, m_fall;

    function automatic longint run_len(input int k);
        return (k == 2) ? longint'(1 + SETTLE + SU + SMP) : longint'(SU + DIG);
    endfunction

    always @(posedge clk) begin
        bit bb;
        e = e + 1;
        if (!rst_n) begin
            m_pend = 0; m_run = 0; m_clr = 0; exp_err = 0;
            m_kind = 0; m_addr = 4'hF; exp_dac = '0; m_s = 0; m_fall = -100000;
        end else begin
            bb = m_pend || m_run;
            if (m_run && (e - m_s == run_len(m_kind))) begin
                m_run = 0;
                if (m_kind == 1) m_clr = 1;
            end
            if (m_pend && blank && (m_kind != 2 || e - m_fall - 1 >= GAP)) begin
                m_pend = 0; m_run = 1; m_s = e;
                if (m_kind == 2) m_fall = e + 1 + SETTLE + SU;
            end
            exp_err = 0;
            if (cmd_valid) begin
                if (bb || cmd_kind == 2'b11 || (!m_clr && cmd_kind != 2'b01)) begin
                    exp_err = 1;
                end else begin
                    m_pend = 1;
                    m_kind = int'(cmd_kind);
                    m_addr = (cmd_kind == 2'b10) ? {1'b0, cmd_addr[2:0]} :
                             (cmd_kind == 2'b01) ? 4'hE : cmd_addr;
                    if (cmd_kind == 2'b10) exp_dac = cmd_data;
                end
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    longint last_zfall = -100000;
    bit     zero_prev = 1;

    always @(negedge clk) begin
        logic [3:0] ea;
        bit es, ez, el, eb;
        longint o, p;
        if (cmp_on) begin
            ea = 4'hF; es = 1; ez = 1; el = 0; eb = m_pend || m_run;
            if (m_run) begin
                o = e - m_s;
                if (m_kind == 2) begin
                    if (o == 0) el = 1;
                    if (o > SETTLE && o <= SETTLE + SU) ea = m_addr;
                    p = o - (1 + SETTLE + SU);
                    if (p >= 0 && p < SMP) begin
                        ea = m_addr; es = 0;
                        if (p >= LEAD && p < LEAD + AZ) ez = 0;
                    end
                end else begin
                    if (o < SU + DIG) ea = m_addr;
                    if (o >= SU && o < SU + DIG) es = 0;
                end
            end
            chk(bus_addr == ea, "R3/R4/R6 bus_addr", bus_addr, ea);
            chk(sample_n == es, "R3/R4/R6 sample_n", sample_n, es);
            chk(zero_n == ez, "R7 zero_n", zero_n, ez);
            chk(dac_load == el, "R5 dac_load", dac_load, el);
            chk(dac_data == exp_dac, "R5 dac_data", dac_data, exp_dac);
            chk(busy == eb, "R9/R10 busy", busy, eb);
            chk(cmd_err == exp_err, "R2/R10/R11 cmd_err", cmd_err, exp_err);
            if (zero_prev && !zero_n) begin
                chk(e - last_zfall > GAP, "R8 analog spacing", e - last_zfall, GAP + 1);
                last_zfall = e;
            end
            zero_prev = zero_n;
        end
    end

    // Watchdog
    int wd = 0;
    always @(negedge clk) begin
        wd++;
        if (wd > 150000 && !finished) begin
            total++; bad++;
            $display("FAIL watchdog R10 actual=%0d expected=%0d", wd, 150000);
            wrap_up();
        end
    end

    task automatic send(input logic [1:0] k, input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cmd_valid = 1; cmd_kind = k; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: values during reset
        chk(bus_addr == 4'hF, "R1 reset addr", bus_addr, 4'hF);
        chk(sample_n && zero_n, "R1 reset strobes", {sample_n, zero_n}, 2'b11);
        chk(!busy && !dac_load && !cmd_err, "R1 reset flags", {busy, dac_load, cmd_err}, 0);
        rst_n = 1;
        cmp_on = 1;
        repeat (3) @(negedge clk);
        chk(bus_addr == 4'hF && !busy, "R1 after reset", {busy, bus_addr}, 4'hF);

        // R2: analog and mode writes before the clear are refused
        send(2'b10, 4'h3, 12'h123);
        chk(cmd_err == 1, "R2 analog before clear err", cmd_err, 1);
        chk(busy == 0, "R2 analog before clear busy", busy, 0);
        send(2'b00, 4'hB, '0);
        chk(cmd_err == 1, "R2 mode before clear err", cmd_err, 1);
        repeat (4) @(negedge clk);
        chk(bus_addr == 4'hF, "R2 bus left idle", bus_addr, 4'hF);

        // R9: clear accepted outside blanking waits
        send(2'b01, 4'h0, '0);
        repeat (30) @(negedge clk);
        chk(busy == 1 && bus_addr == 4'hF, "R9 waiting outside blank", {busy, bus_addr}, 5'h1F);
        blank = 1;
        wait_idle();   // R3 clear checked cycle by cycle

        // R11: illegal kind
        send(2'b11, 4'h2, 12'h0FF);
        chk(cmd_err == 1, "R11 illegal kind err", cmd_err, 1);
        chk(busy == 0, "R11 illegal kind idle", busy, 0);

        // R4: mode writes
        send(2'b00, 4'hB, '0);
        wait_idle();
        send(2'b00, 4'hD, '0);
        wait_idle();

        // R5/R6/R7 analog, blank dropped mid-pulse (R9), busy rejection (R10)
        send(2'b10, 4'h3, 12'hABC);
        repeat (150) @(negedge clk);
        blank = 0;
        send(2'b00, 4'hC, '0);
        chk(cmd_err == 1, "R10 command while busy err", cmd_err, 1);
        chk(busy == 1, "R9 run continues after blank", busy, 1);
        wait_idle();
        blank = 1;

        // R8: back-to-back analog writes are spaced
        send(2'b10, 4'h5, 12'h5A5);
        wait_idle();
        send(2'b10, 4'h8, 12'h000);   // bit 3 ignored: channel 0
        wait_idle();
        send(2'b10, 4'h7, 12'hFFF);
        wait_idle();
        repeat (5) @(negedge clk);
        chk(dac_data == 12'hFFF, "R5 last dac value", dac_data, 12'hFFF);
        chk(bus_addr == 4'hF, "R10 parked at end", bus_addr, 4'hF);
        wrap_up();
    end

endmodule